// File: doc/BRIEF.md
# Coprocessor Control and Status Register Front End

This block is the host-facing register file for a coprocessor whose work is sequenced by a microprogram. A host reaches five 32-bit registers over a simple single-cycle read/write bus: a status word, a microprogram counter (which selects the entry point of the operation to run), a microinstruction register and a data register used for test access, and a data pointer that locates the operation's parameter table. Towards the sequencer the block drives run, single-step and soft-reset pulses, the endian, diagnostic and priority settings, and the held register values. The sequencer answers with a completion pulse, a 16-bit completion code and three error flags.

Writing the microprogram counter while the block is idle launches a full operation, and its completion sets Done. Writing the Step bit instead runs one microinstruction and leaves Done untouched. Done drives a level interrupt when enabled and is cleared by a write-one acknowledge. Any write that arrives while Busy is high is dropped and recorded in a sticky error flag.

Top module: `ucp_csr`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and no sequencer pulse is active.
- R2: The microinstruction register (byte offset 0x08), data pointer (0x10) and data register (0x14) read back what an idle write stored, and the unmapped offset 0x0C reads 0.
- R3: Status bits IE (bit 2), little-endian (bit 4), diagnostic (bit 6) and priority delay (bits 11..8) are read/write, and they drive `seqLittleEndian`, `seqDiag` and `seqPrioDelay`. Bits 0 and 1 are not changed by a write.
- R4: An idle write to the microprogram counter (offset 0x04) stores the value, gives a one-cycle `seqStart` in the cycle after the write edge and sets Busy (bit 0). On the edge that accepts `seqDone`, Busy clears, Done (bit 1) sets, the code is loaded into bits 31..16 and `seqErr` into bits 14..12.
- R5: `irq` is high exactly while Done and IE are both 1.
- R6: An idle status write with bit 3 set clears Done and `irq`. Bit 3 always reads 0.
- R7: An idle status write with bit 5 set gives a one-cycle `seqStep` and sets Busy until `seqDone`. It leaves Done and the completion code unchanged. Bit 5 always reads 0.
- R8: A status write with bits 3 and 5 both set clears Done and starts a step in the same access.
- R9: An idle status write with bit 7 set gives a one-cycle `seqReset` and clears the four data registers, Done, the completion code and the error flags. It suppresses a Step bit set in the same write. Bit 7 always reads 0.
- R10: A write while Busy changes no register and sets sticky flag bit 15. Bit 15 is cleared by an idle acknowledge or soft-reset write.
- R11: A `seqDone` pulse while idle changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 5 | Byte offset of the accessed register |
| hostWrEn | input | 1 | Write strobe, one access per cycle |
| hostWrData | input | 32 | Write data |
| hostRdData | output | 32 | Read data for `hostAddr` (combinational) |
| irq | output | 1 | Level interrupt to the host |
| seqStart | output | 1 | Pulse: run the operation at the microprogram counter |
| seqStep | output | 1 | Pulse: execute one microinstruction |
| seqReset | output | 1 | Pulse: clear sequencer internal state |
| seqLittleEndian | output | 1 | Little-endian data mode |
| seqDiag | output | 1 | Diagnostic mode |
| seqPrioDelay | output | 4 | Priority delay setting |
| seqMpc | output | 32 | Microprogram counter |
| seqMir | output | 32 | Microinstruction register |
| seqDp | output | 32 | Data pointer |
| seqDr | output | 32 | Data register |
| seqDone | input | 1 | Pulse: current run or step has ended |
| seqCode | input | 16 | Completion code |
| seqErr | input | 3 | Sequencer error flags |

## Verification
The hardest cases to reach are those that need the block held busy while the host keeps writing: the dropped writes and the sticky error flag, and an acknowledge combined with a step while Done is still set. The bench uses a sequencer stub with a fixed latency of several cycles. It launches a run and then fires writes to the data pointer and the status word inside that window. It also completes a full run before the combined acknowledge-and-step write, so Done is set when that write arrives. A forced completion pulse while idle covers the spurious-completion case.

// File: rtl/ucp_csr_pkg.sv
package ucp_csr_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 5;
  localparam int CODE_W   = 16;
  localparam int PD_W     = 4;
  localparam int SEQERR_W = 3;

  localparam logic [ADDR_W-1:0] OFF_SR  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_MPC = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_MIR = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_DP  = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_DR  = 5'h14;

  localparam int BIT_IE   = 2;
  localparam int BIT_ACK  = 3;
  localparam int BIT_LE   = 4;
  localparam int BIT_STEP = 5;
  localparam int BIT_DIAG = 6;
  localparam int BIT_RST  = 7;
  localparam int PD_LSB   = 8;

  typedef struct packed {
    logic wrSr;
    logic wrMpc;
    logic wrMir;
    logic wrDp;
    logic wrDr;
    logic softRst;
    logic capture;
  } csrStrobes_t;
endpackage

// File: rtl/ucp_csr_ctrl.sv
module ucp_csr_ctrl
  import ucp_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              seqDone,
  output csrStrobes_t       strobes,
  output logic              busy,
  output logic              done,
  output logic              wbErr,
  output logic              seqStart,
  output logic              seqStep,
  output logic              seqReset
);
  logic stepMode;
  logic wrIdle, srWr, ackReq, rstReq, stepReq, runReq;

  assign wrIdle  = hostWrEn && !busy;
  assign srWr    = wrIdle && (hostAddr == OFF_SR);
  assign ackReq  = srWr && hostWrData[BIT_ACK];
  assign rstReq  = srWr && hostWrData[BIT_RST];
  assign stepReq = srWr && hostWrData[BIT_STEP] && !hostWrData[BIT_RST];
  assign runReq  = wrIdle && (hostAddr == OFF_MPC);

  always_comb begin
    strobes.wrSr    = srWr;
    strobes.wrMpc   = runReq;
    strobes.wrMir   = wrIdle && (hostAddr == OFF_MIR);
    strobes.wrDp    = wrIdle && (hostAddr == OFF_DP);
    strobes.wrDr    = wrIdle && (hostAddr == OFF_DR);
    strobes.softRst = rstReq;
    strobes.capture = busy && seqDone && !stepMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      stepMode <= 1'b0;
      wbErr    <= 1'b0;
      seqStart <= 1'b0;
      seqStep  <= 1'b0;
      seqReset <= 1'b0;
    end else begin
      seqStart <= runReq;
      seqStep  <= stepReq;
      seqReset <= rstReq;
      if (busy) begin
        if (seqDone) begin
          busy <= 1'b0;
          if (!stepMode) done <= 1'b1;
        end
      end else begin
        if (ackReq || rstReq) done <= 1'b0;
        if (runReq) begin
          busy     <= 1'b1;
          stepMode <= 1'b0;
        end else if (stepReq) begin
          busy     <= 1'b1;
          stepMode <= 1'b1;
        end
      end
      if (hostWrEn && busy) wbErr <= 1'b1;
      else if (ackReq || rstReq) wbErr <= 1'b0;
    end
  end

  // R4
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqStart |-> busy);
  // R4
  done_on_finish_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && !$past(stepMode)) |-> done);
  // R7
  step_no_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && $past(stepMode) && !$past(done)) |-> !done);
  // R10
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && busy) |=> wbErr);
  // R7
  launch_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $onehot({seqStart, seqStep}));
endmodule

// File: rtl/ucp_csr_regs.sv
module ucp_csr_regs
  import ucp_csr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  csrStrobes_t         strobes,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic                hostWrEn,
  input  logic [DATA_W-1:0]   hostWrData,
  input  logic                busy,
  input  logic                done,
  input  logic                wbErr,
  input  logic [CODE_W-1:0]   seqCode,
  input  logic [SEQERR_W-1:0] seqErr,
  output logic [DATA_W-1:0]   hostRdData,
  output logic                ieBit,
  output logic                leBit,
  output logic                diagBit,
  output logic [PD_W-1:0]     prioDelay,
  output logic [DATA_W-1:0]   mpcQ,
  output logic [DATA_W-1:0]   mirQ,
  output logic [DATA_W-1:0]   dpQ,
  output logic [DATA_W-1:0]   drQ
);
  logic [CODE_W-1:0]   codeQ;
  logic [SEQERR_W-1:0] errQ;
  logic [DATA_W-1:0]   statusWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ieBit <= 1'b0; leBit <= 1'b0; diagBit <= 1'b0; prioDelay <= '0;
      mpcQ <= '0; mirQ <= '0; dpQ <= '0; drQ <= '0;
      codeQ <= '0; errQ <= '0;
    end else begin
      if (strobes.wrSr) begin
        ieBit     <= hostWrData[BIT_IE];
        leBit     <= hostWrData[BIT_LE];
        diagBit   <= hostWrData[BIT_DIAG];
        prioDelay <= hostWrData[PD_LSB +: PD_W];
      end
      if (strobes.softRst) begin
        mpcQ <= '0; mirQ <= '0; dpQ <= '0; drQ <= '0;
        codeQ <= '0; errQ <= '0;
      end else begin
        if (strobes.wrMpc) mpcQ <= hostWrData;
        if (strobes.wrMir) mirQ <= hostWrData;
        if (strobes.wrDp)  dpQ  <= hostWrData;
        if (strobes.wrDr)  drQ  <= hostWrData;
        if (strobes.capture) begin
          codeQ <= seqCode;
          errQ  <= seqErr;
        end
      end
    end
  end

  assign statusWord = {codeQ, wbErr, errQ, prioDelay, 1'b0, diagBit, 1'b0,
                       leBit, 1'b0, ieBit, done, busy};

  always_comb begin
    case (hostAddr)
      OFF_SR:  hostRdData = statusWord;
      OFF_MPC: hostRdData = mpcQ;
      OFF_MIR: hostRdData = mirQ;
      OFF_DP:  hostRdData = dpQ;
      OFF_DR:  hostRdData = drQ;
      default: hostRdData = '0;
    endcase
  end

  // R10
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && hostWrEn) |=> ($stable(mpcQ) && $stable(dpQ) && $stable(mirQ)
                            && $stable(drQ) && $stable(ieBit)));
  // R9
  soft_reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.softRst |=> (mpcQ == '0 && drQ == '0 && codeQ == '0 && errQ == '0));
endmodule

// File: rtl/ucp_csr.sv
module ucp_csr
  import ucp_csr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic                hostWrEn,
  input  logic [DATA_W-1:0]   hostWrData,
  output logic [DATA_W-1:0]   hostRdData,
  output logic                irq,
  output logic                seqStart,
  output logic                seqStep,
  output logic                seqReset,
  output logic                seqLittleEndian,
  output logic                seqDiag,
  output logic [PD_W-1:0]     seqPrioDelay,
  output logic [DATA_W-1:0]   seqMpc,
  output logic [DATA_W-1:0]   seqMir,
  output logic [DATA_W-1:0]   seqDp,
  output logic [DATA_W-1:0]   seqDr,
  input  logic                seqDone,
  input  logic [CODE_W-1:0]   seqCode,
  input  logic [SEQERR_W-1:0] seqErr
);
  csrStrobes_t strobes;
  logic busy, done, wbErr, ieBit;

  ucp_csr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .seqDone(seqDone), .strobes(strobes),
    .busy(busy), .done(done), .wbErr(wbErr), .seqStart(seqStart),
    .seqStep(seqStep), .seqReset(seqReset)
  );

  ucp_csr_regs u_regs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hostAddr(hostAddr),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData), .busy(busy), .done(done),
    .wbErr(wbErr), .seqCode(seqCode), .seqErr(seqErr), .hostRdData(hostRdData),
    .ieBit(ieBit), .leBit(seqLittleEndian), .diagBit(seqDiag),
    .prioDelay(seqPrioDelay), .mpcQ(seqMpc), .mirQ(seqMir), .dpQ(seqDp),
    .drQ(seqDr)
  );

  assign irq = done && ieBit;

  // R6
  ack_clears_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && !busy && hostAddr == OFF_SR && hostWrData[BIT_ACK]) |=> !irq);
  // R11
  idle_done_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && seqDone && !hostWrEn) |=> ($stable(done) && !busy));
endmodule

// File: tb/ucp_csr_tb.sv
module ucp_csr_tb;
  import ucp_csr_pkg::*;

  localparam int LAT = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] hostAddr = '0;
  logic hostWrEn = 1'b0;
  logic [DATA_W-1:0] hostWrData = '0;
  logic [DATA_W-1:0] hostRdData;
  logic irq, seqStart, seqStep, seqReset, seqLittleEndian, seqDiag;
  logic [PD_W-1:0] seqPrioDelay;
  logic [DATA_W-1:0] seqMpc, seqMir, seqDp, seqDr;
  logic [CODE_W-1:0] seqCode = '0;
  logic [SEQERR_W-1:0] seqErr = '0;
  logic stubDone = 1'b0;
  logic forceDone = 1'b0;
  logic seqDone;
  int stubCnt = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  assign seqDone = stubDone || forceDone;
  always #10 clk = ~clk;

  ucp_csr u_dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .irq(irq),
    .seqStart(seqStart), .seqStep(seqStep), .seqReset(seqReset),
    .seqLittleEndian(seqLittleEndian), .seqDiag(seqDiag),
    .seqPrioDelay(seqPrioDelay), .seqMpc(seqMpc), .seqMir(seqMir),
    .seqDp(seqDp), .seqDr(seqDr), .seqDone(seqDone), .seqCode(seqCode),
    .seqErr(seqErr)
  );

  // Sequencer stub: completes LAT cycles after a launch pulse.
  always @(posedge clk) begin
    if (!rstN) begin
      stubCnt  <= 0;
      stubDone <= 1'b0;
    end else begin
      stubDone <= 1'b0;
      if (seqStart || seqStep) stubCnt <= LAT;
      else if (stubCnt != 0) begin
        stubCnt <= stubCnt - 1;
        if (stubCnt == 1) stubDone <= 1'b1;
      end
    end
  end

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] exp;
    string tag;
  } rdItem_t;
  rdItem_t rdQ[$];

  // Monitor: compares read data at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (rdQ.size() > 0) begin
        rdItem_t it;
        it = rdQ.pop_front();
        checks++;
        if (hostRdData !== it.exp) begin
          errors++;
          $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, hostRdData, it.exp);
        end
      end
    end
  end

  task automatic expectRead(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string tag);
    rdItem_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    hostAddr = a;
    rdQ.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(posedge clk); #1;
    hostWrEn = 1'b0;
  endtask

  task automatic checkSig(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitFinish();
    int guard = 0;
    @(negedge clk);
    while (!stubDone && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    @(posedge clk); #1;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    checkSig(irq, 0, "R1 irq");
    checkSig({seqStart, seqStep, seqReset}, 0, "R1 pulses");
    expectRead(OFF_SR, 32'h0, "R1 status");
    expectRead(OFF_MPC, 32'h0, "R1 mpc");
    // R2 data registers
    busWrite(OFF_MIR, 32'hA5A5_0F0F);
    busWrite(OFF_DP, 32'h0000_1230);
    busWrite(OFF_DR, 32'hDEAD_BEEF);
    expectRead(OFF_MIR, 32'hA5A5_0F0F, "R2 mir");
    expectRead(OFF_DP, 32'h0000_1230, "R2 dp");
    expectRead(OFF_DR, 32'hDEAD_BEEF, "R2 dr");
    expectRead(5'h0C, 32'h0, "R2 unmapped");
    // R3 config bits; bits 0,1 written high have no effect
    busWrite(OFF_SR, 32'h0000_0A57);
    expectRead(OFF_SR, 32'h0000_0A54, "R3 status");
    checkSig({seqLittleEndian, seqDiag, seqPrioDelay}, 6'b11_1010, "R3 outputs");
    // R4 full run
    seqCode = 16'hBEEF; seqErr = 3'b101;
    busWrite(OFF_MPC, 32'h0000_0040);
    checkSig(seqStart, 1, "R4 seqStart");
    expectRead(OFF_SR, 32'h0000_0A55, "R4 busy");
    checkSig(seqStart, 0, "R4 seqStart one cycle");
    waitFinish();
    expectRead(OFF_SR, 32'hBEEF_5A56, "R4 done code err");
    expectRead(OFF_MPC, 32'h0000_0040, "R4 mpc");
    checkSig(irq, 1, "R5 irq on");
    // R5 IE gating
    busWrite(OFF_SR, 32'h0000_0A50);
    checkSig(irq, 0, "R5 irq masked");
    expectRead(OFF_SR, 32'hBEEF_5A52, "R5 done kept");
    busWrite(OFF_SR, 32'h0000_0A54);
    checkSig(irq, 1, "R5 irq reenabled");
    // R6 acknowledge
    busWrite(OFF_SR, 32'h0000_0A5C);
    checkSig(irq, 0, "R6 irq cleared");
    expectRead(OFF_SR, 32'hBEEF_5A54, "R6 done cleared");
    // R7 single step
    seqCode = 16'h1234; seqErr = 3'b000;
    busWrite(OFF_SR, 32'h0000_0A74);
    checkSig(seqStep, 1, "R7 seqStep");
    checkSig(seqStart, 0, "R7 no seqStart");
    expectRead(OFF_SR, 32'hBEEF_5A55, "R7 busy");
    waitFinish();
    expectRead(OFF_SR, 32'hBEEF_5A54, "R7 no done, code kept");
    // R8 ack + step with Done set
    busWrite(OFF_MPC, 32'h0000_0044);
    waitFinish();
    expectRead(OFF_SR, 32'h1234_0A56, "R8 setup done");
    busWrite(OFF_SR, 32'h0000_0A7C);
    checkSig(seqStep, 1, "R8 seqStep");
    checkSig(irq, 0, "R8 irq cleared");
    expectRead(OFF_SR, 32'h1234_0A55, "R8 done clear busy set");
    waitFinish();
    // R10 writes while busy
    busWrite(OFF_MPC, 32'h0000_0080);
    busWrite(OFF_DP, 32'hFFFF_FFFF);
    busWrite(OFF_SR, 32'h0000_0000);
    expectRead(OFF_DP, 32'h0000_1230, "R10 dp unchanged");
    expectRead(OFF_SR, 32'h1234_8A55, "R10 sticky set, cfg kept");
    waitFinish();
    expectRead(OFF_SR, 32'h1234_8A56, "R10 sticky holds");
    busWrite(OFF_SR, 32'h0000_0A5C);
    expectRead(OFF_SR, 32'h1234_0A54, "R10 sticky cleared by ack");
    // R11 spurious completion while idle
    seqCode = 16'h7777;
    forceDone = 1'b1;
    @(posedge clk); #1;
    forceDone = 1'b0;
    expectRead(OFF_SR, 32'h1234_0A54, "R11 idle done ignored");
    // R9 soft reset with done set and step bit also set
    busWrite(OFF_MPC, 32'h0000_0010);
    waitFinish();
    busWrite(OFF_SR, 32'h0000_03A4);
    checkSig(seqReset, 1, "R9 seqReset");
    checkSig(seqStep, 0, "R9 step suppressed");
    expectRead(OFF_SR, 32'h0000_0304, "R9 status cleared");
    checkSig(seqReset, 0, "R9 seqReset one cycle");
    expectRead(OFF_MPC, 32'h0, "R9 mpc");
    expectRead(OFF_MIR, 32'h0, "R9 mir");
    expectRead(OFF_DP, 32'h0, "R9 dp");
    expectRead(OFF_DR, 32'h0, "R9 dr");
    @(posedge clk); #1;
    report();
  end
endmodule